// File: doc/BRIEF.md
# Sequential Read Prefetch Buffer

This block sits between the read port of a bus target and a slower local-bus read master. A host read whose address does not continue the current stream makes the block discard what it holds and fetch the addressed word from the local bus. From then on the block stays ahead of the host. Up to a programmable number of 32-bit words are held in an eight-entry buffer or are in flight. Fetching goes on whether or not the host is reading at that moment.

A host read is answered in the same cycle when two things hold: its address is the stream's next address, that is, the previous read address plus 4, and the buffer head already holds that word. Any other read waits. The same is true of any write access. Either one empties the buffer and resets the stream. A local-bus request that is already outstanding is always carried to its acknowledge, and the word it returns is then dropped. Near the top of the address region the block stops running ahead. It never requests a word at or above the region's end.

Top module: `pfb_prefetch_buf`

## Requirements
- R1: While reset is active and after it is released, `lb_req` and `hst_rd_rdy` are low and the buffer holds no words.
- R2: The number of words held in the buffer plus the number in flight on the local bus never exceeds eight.
- R3: A read presented while no stream is active gets no response in that cycle. The next local request the block issues is for exactly that address.
- R4: `pf_mode` sets how many words may be held or in flight, counted from the next address the host will read: 0 gives 1 (demand fetch only), 1 gives 2, 2 gives 4, 3 gives 8. The block fills up to this limit while the host is idle.
- R5: `hst_rd_rdy` is high only for a read of the stream's next address. In that cycle `hst_rd_data` is the full 32-bit word the local bus returned for that address.
- R6: A read whose address differs from the previous read address plus 4 gets no response in that cycle. It restarts the stream, and the next local request is for the new address.
- R7: A write access (`hst_wr` high) empties the buffer. No local request starts after it until the next read arrives.
- R8: Once raised, `lb_req` stays high with a stable `lb_addr` until the cycle in which `lb_ack` is high, even across a flush. The word that a request pending at a flush returns is never delivered to the host.
- R9: Once the stream's next address is at or above `rgn_base + rgn_size - 32`, only the word at that address is fetched, and nothing ahead of it.
- R10: Every local request address lies in `[rgn_base, rgn_base + rgn_size)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pf_mode | input | 2 | Look-ahead depth code (0 off, 1 two, 2 four, 3 eight words) |
| rgn_base | input | 32 | Byte address of the region start |
| rgn_size | input | 32 | Region size in bytes, at least 32 |
| hst_rd_req | input | 1 | Host read request, held until answered |
| hst_addr | input | 32 | Word-aligned host read address |
| hst_wr | input | 1 | Host write access seen by the target (flush pulse) |
| hst_rd_rdy | output | 1 | Read answered this cycle |
| hst_rd_data | output | 32 | Read data |
| lb_req | output | 1 | Local-bus word request |
| lb_addr | output | 32 | Local-bus word address |
| lb_ack | input | 1 | Local-bus acknowledge, one cycle per word |
| lb_data | input | 32 | Local-bus word, valid with `lb_ack` |

## Verification
The hardest case to reach is a flush that arrives while a local request is still waiting for its acknowledge. The stale word must be dropped, and the new stream's first request must not start until that acknowledge has come back. The bench's local-bus responder acknowledges after a random delay of zero to three cycles. The host stream is interrupted by random jumps and writes, so flushes land at every point in a pending request's life. Runs that approach the region end, with idle gaps, let the look-ahead fill to its limit just before and inside the guard window.

// File: rtl/pfb_pkg.sv
// Shared types for the sequential read prefetch buffer.
// Assumes: look-ahead depth is chosen by a two-bit code.
package pfb_pkg;
    typedef enum logic [1:0] {
        PF_OFF = 2'd0,
        PF_2   = 2'd1,
        PF_4   = 2'd2,
        PF_8   = 2'd3
    } pf_depth_e;
endpackage

// File: rtl/pfb_store.sv
// Word store for the prefetch buffer: a circular queue with push, pop and
// a one-cycle flush that empties it.
// Assumes: DEPTH is a power of two; the caller never pushes when full,
// never pops when empty, and never pushes in a flush cycle.
module pfb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] slots_q [DEPTH];
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_ptr_q;

    // Write the arriving word into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slots_q[wr_ptr_q] <= push_data;
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_data = slots_q[rd_ptr_q];

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/pfb_window.sv
// Fetch-window decision: works out whether one more word may be requested,
// from the depth code, the occupancy, and the region limits.
// Assumes: rgn_size >= GUARD_WORDS*4, word-aligned addresses, and that the
// caller's fetch address equals head address + 4*(held + in flight).
module pfb_window
    import pfb_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DEPTH       = 8,
    parameter int GUARD_WORDS = 8,
    parameter int CW          = $clog2(DEPTH + 1)
) (
    input  pf_depth_e     mode,
    input  logic [AW-1:0] rgn_base,
    input  logic [AW-1:0] rgn_size,
    input  logic [AW-1:0] head_addr,
    input  logic [AW-1:0] fetch_addr,
    input  logic [CW-1:0] count,
    output logic          may_fetch,
    output logic          near_end,
    output logic [AW-1:0] end_addr
);
    localparam int            LIM8        = (DEPTH < 8) ? DEPTH : 8;
    localparam logic [AW-1:0] GUARD_BYTES = AW'(GUARD_WORDS * 4);

    logic [CW-1:0] limit;
    logic [AW-1:0] guard_addr;
    logic          in_region;

    // Translate the depth code into a word limit.
    always_comb begin
        case (mode)
            PF_OFF:  limit = CW'(1);
            PF_2:    limit = CW'(2);
            PF_4:    limit = CW'(4);
            default: limit = CW'(LIM8);
        endcase
    end

    // Region bounds and the final go/no-go for a new request.
    always_comb begin
        end_addr   = rgn_base + rgn_size;
        guard_addr = end_addr - GUARD_BYTES;
        near_end   = (head_addr >= guard_addr);
        in_region  = (fetch_addr >= rgn_base) && (fetch_addr < end_addr);
        may_fetch  = in_region && ((count == '0) || (!near_end && (count < limit)));
    end
endmodule

// File: rtl/pfb_prefetch_buf.sv
// Sequential read prefetch buffer (top). It tracks one read stream: the
// head address (the next word the host may read) and the fetch address
// (the next word to request). A read that misses the head address, or any
// write, flushes the stream. A pending local request is always completed,
// and its word is dropped if a flush came in between.
// Assumes: host addresses are word-aligned; hst_wr and hst_rd_req are not
// both high in one cycle; region inputs change only while no stream is
// active.
module pfb_prefetch_buf
    import pfb_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int DEPTH       = 8,
    parameter int GUARD_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pf_mode,
    input  logic [AW-1:0] rgn_base,
    input  logic [AW-1:0] rgn_size,
    input  logic          hst_rd_req,
    input  logic [AW-1:0] hst_addr,
    input  logic          hst_wr,
    output logic          hst_rd_rdy,
    output logic [DW-1:0] hst_rd_data,
    output logic          lb_req,
    output logic [AW-1:0] lb_addr,
    input  logic          lb_ack,
    input  logic [DW-1:0] lb_data
);
    localparam int            CW        = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);

    logic          active_q, pend_q, drop_q;
    logic [AW-1:0] head_q, fetch_q, lbaddr_q;
    logic [CW-1:0] buf_cnt;
    logic [DW-1:0] head_data;
    logic          may_fetch, near_end;
    logic [AW-1:0] end_addr;
    logic          seq_hit, restart, flush, pop, push, issue;

    pfb_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (lb_data),
        .pop       (pop),
        .head_data (head_data),
        .count     (buf_cnt)
    );

    pfb_window #(.AW(AW), .DEPTH(DEPTH), .GUARD_WORDS(GUARD_WORDS), .CW(CW)) u_window (
        .mode       (pf_depth_e'(pf_mode)),
        .rgn_base   (rgn_base),
        .rgn_size   (rgn_size),
        .head_addr  (head_q),
        .fetch_addr (fetch_q),
        .count      (buf_cnt),
        .may_fetch  (may_fetch),
        .near_end   (near_end),
        .end_addr   (end_addr)
    );

    // Classify this cycle's host access and the local-bus events.
    always_comb begin
        seq_hit = active_q && (hst_addr == head_q);
        restart = hst_rd_req && !hst_wr && !seq_hit;
        flush   = hst_wr || restart;
        pop     = hst_rd_req && !hst_wr && seq_hit && (buf_cnt != '0);
        push    = lb_ack && pend_q && !drop_q && !flush;
        issue   = active_q && !pend_q && !flush && may_fetch;
    end

    // Stream state and the local request handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            drop_q   <= 1'b0;
            head_q   <= '0;
            fetch_q  <= '0;
            lbaddr_q <= '0;
        end else if (flush) begin
            active_q <= !hst_wr;
            head_q   <= hst_addr;
            fetch_q  <= hst_addr;
            if (pend_q) begin
                pend_q <= !lb_ack;
                drop_q <= !lb_ack;
            end
        end else begin
            if (pop) head_q <= head_q + WORD_STEP;
            if (pend_q && lb_ack) begin
                pend_q <= 1'b0;
                drop_q <= 1'b0;
            end
            if (issue) begin
                pend_q   <= 1'b1;
                lbaddr_q <= fetch_q;
                fetch_q  <= fetch_q + WORD_STEP;
            end
        end
    end

    assign hst_rd_rdy  = pop;
    assign hst_rd_data = head_data;
    assign lb_req      = pend_q;
    assign lb_addr     = lbaddr_q;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_req && !lb_ack) |=> (lb_req && $stable(lb_addr)));

    // R10
    in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_req |-> ((lb_addr >= rgn_base) && (lb_addr < end_addr)));

    // R7
    quiet_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hst_wr) |-> !$rose(lb_req));

    // R9
    guard_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lb_req) && $past(near_end)) |-> (lb_addr == $past(head_q)));

    // R4
    off_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lb_req) && ($past(pf_mode) == 2'd0)) |-> (lb_addr == $past(head_q)));

    // R5
    rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rd_rdy |-> (hst_rd_req && !hst_wr));
endmodule

// File: tb/tb_pfb_prefetch_buf.sv
// Bench: behavioural host stream model, a randomly delayed local-bus
// responder backed by a computed memory, and checks made every cycle.
module tb_pfb_prefetch_buf;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] SIZE  = 32'h0000_0200;
    localparam logic [31:0] ENDA  = BASE + SIZE;
    localparam logic [31:0] GUARD = ENDA - 32'd32;

    typedef struct { int kind; int val; } op_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  pf_mode;
    logic        hst_rd_req, hst_wr, lb_ack;
    logic [31:0] hst_addr, lb_data;
    logic        hst_rd_rdy, lb_req;
    logic [31:0] hst_rd_data, lb_addr;

    int total = 0, bad = 0;
    op_t ops[$];

    always #4 clk = ~clk;

    pfb_prefetch_buf dut (
        .clk(clk), .rst_n(rst_n), .pf_mode(pf_mode), .rgn_base(BASE), .rgn_size(SIZE),
        .hst_rd_req(hst_rd_req), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd_rdy(hst_rd_rdy), .hst_rd_data(hst_rd_data),
        .lb_req(lb_req), .lb_addr(lb_addr), .lb_ack(lb_ack), .lb_data(lb_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F1E ^ (a << 11);
    endfunction

    function automatic int lim_of(input logic [1:0] m);
        case (m)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic add(input int k, input int v);
        op_t o;
        o.kind = k;
        o.val  = v;
        ops.push_back(o);
    endtask

    // model state
    logic [31:0] h = '0, h_prev = '0, prev_addr = '0, data_nxt = '0;
    bit act = 0, act_prev = 0, expect_first = 0, prev_req = 0, prev_ack = 0, ack_nxt = 0;
    int lat = 0, max_k = -1;

    task automatic sample_cycle();
        bit rising;
        int k;
        logic [31:0] h_save;
        bit act_save;
        rising = lb_req && !prev_req;
        if (prev_req && !prev_ack)
            chk(lb_req && (lb_addr == prev_addr), "R8 request held", lb_addr, prev_addr);
        if (rising) begin
            lat = $urandom_range(0, 3);
            if (!act_prev) begin
                chk(1'b0, "R7 request after write", lb_addr, 32'h0);
            end else begin
                k = (int'(lb_addr) - int'(h_prev)) / 4;
                chk((lb_addr >= BASE) && (lb_addr < ENDA), "R10 request in region", lb_addr, ENDA);
                chk((k >= 0) && (k < 8), "R2 at most eight words", 32'(k), 32'd7);
                chk(k < lim_of(pf_mode), "R4 look-ahead limit", 32'(k), 32'(lim_of(pf_mode) - 1));
                if (h_prev >= GUARD)
                    chk(k == 0, "R9 guard window", lb_addr, h_prev);
                if (expect_first) begin
                    chk(lb_addr == h_prev, "R3/R6 first request address", lb_addr, h_prev);
                    expect_first = 0;
                end
                if (k > max_k) max_k = k;
            end
        end
        h_save   = h;
        act_save = act;
        if (hst_wr) begin
            act = 0;
            chk(!hst_rd_rdy, "R7 no answer on write", 32'(hst_rd_rdy), 32'h0);
        end else if (hst_rd_req) begin
            if (!act || hst_addr != h) begin
                chk(!hst_rd_rdy, act ? "R6 restart costs a cycle" : "R3 first read waits",
                    32'(hst_rd_rdy), 32'h0);
                act = 1;
                h = hst_addr;
                expect_first = 1;
            end else if (hst_rd_rdy) begin
                chk(hst_rd_data == mem_word(hst_addr), "R5 read data", hst_rd_data, mem_word(hst_addr));
                h = h + 32'd4;
            end
        end else begin
            chk(!hst_rd_rdy, "R5 no answer without read", 32'(hst_rd_rdy), 32'h0);
        end
        h_prev   = h_save;
        act_prev = act_save;
        if (lb_ack) ack_nxt = 0;
        else if (lb_req) begin
            if (lat == 0) begin
                ack_nxt  = 1;
                data_nxt = mem_word(lb_addr);
            end else lat--;
        end
        prev_req  = lb_req;
        prev_ack  = lb_ack;
        prev_addr = lb_addr;
    endtask

    initial begin
        int oi, idle_left, drain, cycles, waitcnt;
        bit advance, fresh, finished;
        rst_n = 1'b0; pf_mode = 2'd0; hst_rd_req = 1'b0; hst_wr = 1'b0;
        hst_addr = '0; lb_ack = 1'b0; lb_data = '0;
        repeat (3) @(negedge clk);
        #2;
        chk(!lb_req && !hst_rd_rdy, "R1 outputs in reset", {30'h0, lb_req, hst_rd_rdy}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!lb_req && !hst_rd_rdy, "R1 outputs after reset", {30'h0, lb_req, hst_rd_rdy}, 32'h0);
        chk(!lb_req, "R1 no fetch while idle", 32'(lb_req), 32'h0);

        // clean runs per depth code, with an idle gap to fill the look-ahead
        for (int m = 0; m < 4; m++) begin
            add(1, 0); add(4, m); add(0, int'(BASE)); add(2, 60);
            for (int i = 1; i < 16; i++) add(0, int'(BASE) + 4 * i);
            add(3, 0);
        end
        // write then continuing address must still restart
        add(0, int'(BASE) + 64); add(0, int'(BASE) + 68); add(1, 0);
        add(0, int'(BASE) + 72); add(0, int'(BASE) + 76);
        // random jumps and writes
        for (int s = 0; s < 24; s++) begin
            int st, ln;
            if (s == 0)  begin add(1, 0); add(4, 3); end
            if (s == 12) begin add(1, 0); add(4, 1); end
            st = int'(BASE) + 4 * $urandom_range(0, 110);
            ln = $urandom_range(1, 6);
            for (int i = 0; i < ln; i++) add(0, st + 4 * i);
            if ($urandom_range(0, 3) == 0) add(1, 0);
            if ($urandom_range(0, 2) == 0) add(2, $urandom_range(1, 8));
        end
        // runs into the region end
        for (int r = 0; r < 3; r++) begin
            add(1, 0); add(4, (r == 0) ? 3 : r);
            add(0, int'(GUARD) - 16); add(2, 50);
            for (int a = int'(GUARD) - 12; a < int'(ENDA); a += 4) begin
                add(0, a);
                if (a == int'(GUARD)) add(2, 20);
            end
            add(2, 20);
        end

        oi = 0; advance = 0; fresh = 1; finished = 0; drain = 0; cycles = 0; waitcnt = 0; idle_left = 0;
        while (!finished) begin
            @(negedge clk);
            if (advance) begin oi++; fresh = 1; advance = 0; waitcnt = 0; end
            while (oi < ops.size() && ops[oi].kind >= 3) begin
                if (ops[oi].kind == 3) begin
                    chk(max_k == lim_of(pf_mode) - 1, "R4 look-ahead fills while idle",
                        32'(max_k), 32'(lim_of(pf_mode) - 1));
                    max_k = -1;
                end else begin
                    pf_mode = 2'(ops[oi].val);
                end
                oi++;
                fresh = 1;
            end
            if (oi >= ops.size()) begin
                hst_rd_req = 1'b0; hst_wr = 1'b0;
                drain++;
                if (drain > 10) finished = 1;
            end else begin
                case (ops[oi].kind)
                    0: begin hst_rd_req = 1'b1; hst_wr = 1'b0; hst_addr = 32'(ops[oi].val); end
                    1: begin hst_rd_req = 1'b0; hst_wr = 1'b1; end
                    default: begin
                        hst_rd_req = 1'b0; hst_wr = 1'b0;
                        if (fresh) idle_left = ops[oi].val;
                    end
                endcase
            end
            fresh = 0;
            lb_ack  = ack_nxt;
            lb_data = data_nxt;
            #2;
            sample_cycle();
            if (oi < ops.size()) begin
                case (ops[oi].kind)
                    0: if (hst_rd_rdy) advance = 1; else waitcnt++;
                    1: advance = 1;
                    default: begin idle_left--; if (idle_left <= 0) advance = 1; end
                endcase
            end
            cycles++;
            if (cycles > 150000 || waitcnt > 1000) begin
                chk(1'b0, "watchdog", 32'(cycles), 32'(waitcnt));
                finished = 1;
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule